// File: doc/BRIEF.md
# Match-Clear Timer Channel

This block is a single timer channel built around a 16-bit up-counter. The counter advances on count events derived from either a divided copy of the system clock or an external clock pin, and four compare registers watch its value. A control register chooses the count source, which edge or edges of that source produce a count event, and which compare register, if any, returns the counter to zero.

Software reaches the control, counter, compare and flag registers through a plain synchronous bus. A write takes effect on the rising clock edge, and read data is combinational from the address. A run input starts and stops counting. Each compare register has a sticky match flag. The flag is visible on a dedicated output and through the bus, and software clears it by writing a one to its bit.

Register addresses: 0 control, 1 counter, 2 to 5 compare A to D, 6 match flags (bit 0 is A up to bit 3 for D, write-one-to-clear), 7 reads as zero. Control fields: bits 7:5 clear select, bits 4:3 edge select, bits 2:0 source select.

Top module: `match_clear_timer`

## Requirements
- R1: Control bits 15:8 always read 0 and ignore writes. Bits 7:0 read back what was written.
- R2: A control write made while `runEn` is 1 leaves the control register unchanged.
- R3: While `runEn` is 0 the counter keeps its value unless the bus writes it.
- R4: Source code 000 (undivided clock) adds 1 to the counter on every clock while running, for every edge-select value.
- R5: Source codes 001, 010 and 011 divide the clock by 4, 16 and 64. Edge select 00 (rising) and 01 (falling) give one count per division period. Edge select 1x (both) gives two.
- R6: Source codes 1xx count the external pin after a two-flop synchronizer: rising transitions for 00, falling transitions for 01, and all transitions for 1x.
- R7: Clear select 001, 010, 101 and 110 choose compare A, B, C and D. On a count event where the counter equals the chosen compare value, the counter loads 0 instead of incrementing.
- R8: Clear select 000, 100, 011 and 111 never clear the counter, and the counter wraps from 0xFFFF to 0x0000.
- R9: Match flag n is set on a count event where the counter equals compare n. It stays set until a write to address 6 with bit n set to 1.
- R10: The counter and the four compare registers read back the last value written to them.
- R11: After reset the control register is 0, the counter is 0, every compare register is 0xFFFF and every flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| runEn | input | 1 | Counting enabled while 1 |
| extClk | input | 1 | External count clock pin, asynchronous |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for busAddr |
| matchFlag | output | 4 | Sticky compare-match flags, A in bit 0 |

## Verification
A wrong source or edge decode shows up as a wrong count after a fixed run window. Each window spans a whole number of division periods, so the expected count does not depend on the prescaler phase. A bad clear decode or compare path shows up as a counter value or flag that departs from the reference sequence on the first count event that passes the chosen compare value, which is within one tick of the fault. Faults in control-write gating and flag stickiness appear on the very next bus read after the stimulus that should have been ignored.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;
  localparam int NUM_CMP = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMP0 = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd6;

  // Strobes from control to datapath
  typedef struct packed {
    logic               tick;     // one count event this cycle
    logic [NUM_CMP-1:0] clrPick;  // compare register that clears the counter
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int DIV_STEP = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic       extClk,
  input  logic       ctrlWr,
  input  logic [7:0] ctrlWrData,
  output logic [7:0] ctrlReg,
  output tmrStrobe_t strb
);
  localparam int PRE_W = 3 * DIV_STEP;
  localparam int TAP1  = DIV_STEP - 1;
  localparam int TAP2  = 2 * DIV_STEP - 1;
  localparam int TAP3  = 3 * DIV_STEP - 1;

  logic [PRE_W-1:0] divCnt;
  logic [1:0]       extSync;
  logic             selLevel;
  logic             prevLevel;
  logic             riseHit;
  logic             fallHit;
  logic             edgeHit;
  logic             fastSrc;

  // Control register: writes are ignored while running
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ctrlReg <= '0;
    else if (ctrlWr && !runEn) ctrlReg <= ctrlWrData;
  end

  // Free-running prescaler and external pin synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      extSync   <= '0;
      prevLevel <= 1'b0;
    end else begin
      divCnt    <= divCnt + 1'b1;
      extSync   <= {extSync[0], extClk};
      prevLevel <= selLevel;
    end
  end

  always_comb begin
    unique case (ctrlReg[2:0])
      3'b000:  selLevel = 1'b0;
      3'b001:  selLevel = divCnt[TAP1];
      3'b010:  selLevel = divCnt[TAP2];
      3'b011:  selLevel = divCnt[TAP3];
      default: selLevel = extSync[1];
    endcase
  end

  assign fastSrc = (ctrlReg[2:0] == 3'b000);
  assign riseHit = selLevel & ~prevLevel;
  assign fallHit = ~selLevel & prevLevel;

  always_comb begin
    if (ctrlReg[4])      edgeHit = riseHit | fallHit;
    else if (ctrlReg[3]) edgeHit = fallHit;
    else                 edgeHit = riseHit;
  end

  assign strb.tick = runEn & (fastSrc | edgeHit);

  // Clear-source decode; reserved codes mean no clearing
  always_comb begin
    unique case (ctrlReg[7:5])
      3'b001:  strb.clrPick = 4'b0001;
      3'b010:  strb.clrPick = 4'b0010;
      3'b101:  strb.clrPick = 4'b0100;
      3'b110:  strb.clrPick = 4'b1000;
      default: strb.clrPick = 4'b0000;
    endcase
  end

  // R2: control register frozen while running
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    runEn |=> ctrlReg == $past(ctrlReg));

  // R3: no count event while stopped
  p_run_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !strb.tick);

  // R4: undivided source ticks every running cycle
  p_fast_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && ctrlReg[2:0] == 3'b000) |-> strb.tick);

  // R7: at most one clear source
  p_clr_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.clrPick));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrobe_t         strb,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [CNT_W-1:0]   busWrData,
  input  logic [7:0]         ctrlView,
  output logic [CNT_W-1:0]   busRdData,
  output logic [NUM_CMP-1:0] matchFlag
);
  logic [CNT_W-1:0]   counter;
  logic [CNT_W-1:0]   cmpReg [NUM_CMP];
  logic [NUM_CMP-1:0] matchNow;
  logic               cntWr;
  logic               flagWr;
  logic               clrHit;

  assign cntWr  = busWe && (busAddr == ADDR_CNT);
  assign flagWr = busWe && (busAddr == ADDR_FLAG);

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    logic cmpWr;
    assign cmpWr       = busWe && (busAddr == ADDR_W'(ADDR_CMP0 + i));
    assign matchNow[i] = (counter == cmpReg[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      cmpReg[i] <= '1;
      else if (cmpWr) cmpReg[i] <= busWrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                             matchFlag[i] <= 1'b0;
      else if (strb.tick && matchNow[i])     matchFlag[i] <= 1'b1;
      else if (flagWr && busWrData[i])       matchFlag[i] <= 1'b0;
    end
  end

  assign clrHit = |(strb.clrPick & matchNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          counter <= '0;
    else if (cntWr)     counter <= busWrData;
    else if (strb.tick) counter <= clrHit ? '0 : counter + 1'b1;
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_CTRL)      busRdData = CNT_W'(ctrlView);
    else if (busAddr == ADDR_CNT)  busRdData = counter;
    else if (busAddr == ADDR_FLAG) busRdData = CNT_W'(matchFlag);
    else begin
      for (int i = 0; i < NUM_CMP; i++)
        if (busAddr == ADDR_W'(ADDR_CMP0 + i)) busRdData = cmpReg[i];
    end
  end

  // R3: counter holds without a tick or write
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !cntWr) |=> counter == $past(counter));

  // R4 / R8: plain increment with wrap
  p_cnt_inc_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !clrHit && !cntWr) |=> counter == CNT_W'($past(counter) + 1'b1));

  // R7: selected match clears on the count event
  p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && clrHit && !cntWr) |=> counter == '0);

  // R9: flags stay set without a flag write
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    !flagWr |=> (matchFlag & $past(matchFlag)) == $past(matchFlag));
endmodule

// File: rtl/match_clear_timer.sv
module match_clear_timer
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic        extClk,
  input  logic        busWe,
  input  logic [2:0]  busAddr,
  input  logic [15:0] busWrData,
  output logic [15:0] busRdData,
  output logic [3:0]  matchFlag
);
  tmrStrobe_t strb;
  logic [7:0] ctrlReg;
  logic       ctrlWr;

  assign ctrlWr = busWe && (busAddr == ADDR_CTRL);

  tmr_ctrl #(.DIV_STEP(2)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .runEn      (runEn),
    .extClk     (extClk),
    .ctrlWr     (ctrlWr),
    .ctrlWrData (busWrData[7:0]),
    .ctrlReg    (ctrlReg),
    .strb       (strb)
  );

  tmr_datapath #(.CNT_W(16)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .ctrlView  (ctrlReg),
    .busRdData (busRdData),
    .matchFlag (matchFlag)
  );
endmodule

// File: tb/match_clear_timer_tb_top.sv
module match_clear_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic        extClk = 1'b0;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [3:0]  matchFlag;

  int nChecks = 0;
  int nFail = 0;

  match_clear_timer dut_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .extClk(extClk),
    .busWe(busWe), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .matchFlag(matchFlag)
  );

  always #10 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog R3: run did not finish, actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    busAddr = a;
    #1 v = busRdData;
  endtask

  task automatic runFor(input int n);
    @(negedge clk);
    runEn = 1'b1;
    repeat (n) @(negedge clk);
    runEn = 1'b0;
  endtask

  // Reference: counter and flags after n count events
  task automatic model(input logic [2:0] code, input logic [15:0] c0, input logic [15:0] c1,
                       input logic [15:0] c2, input logic [15:0] c3, input logic [15:0] start,
                       input int n, output logic [15:0] cnt, output logic [3:0] fl);
    logic [15:0] cmp [4];
    int pick;
    cmp[0] = c0; cmp[1] = c1; cmp[2] = c2; cmp[3] = c3;
    case (code)
      3'b001: pick = 0;
      3'b010: pick = 1;
      3'b101: pick = 2;
      3'b110: pick = 3;
      default: pick = -1;
    endcase
    cnt = start;
    fl = '0;
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 4; i++) if (cnt == cmp[i]) fl[i] = 1'b1;
      if (pick >= 0 && cnt == cmp[pick]) cnt = '0;
      else cnt = cnt + 16'd1;
    end
  endtask

  initial begin
    logic [15:0] v, expCnt, ca, cb, cc, cd, st;
    logic [3:0]  expFl;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11 reset state
    rd(3'd0, v); check("R11 ctrl", v, 16'h0000);
    rd(3'd1, v); check("R11 counter", v, 16'h0000);
    for (int i = 0; i < 4; i++) begin
      rd(3'(2 + i), v); check("R11 compare", v, 16'hFFFF);
    end
    rd(3'd6, v); check("R11 flags", v, 16'h0000);

    // R1 upper control bits
    wr(3'd0, 16'hABC1); rd(3'd0, v); check("R1 ctrl upper", v, 16'h00C1);
    wr(3'd0, 16'hFF00); rd(3'd0, v); check("R1 ctrl upper only", v, 16'h0000);

    // R10 register readback
    wr(3'd1, 16'h1234); rd(3'd1, v); check("R10 counter", v, 16'h1234);
    for (int i = 0; i < 4; i++) begin
      wr(3'(2 + i), 16'h0A00 + 16'(i)); rd(3'(2 + i), v); check("R10 compare", v, 16'h0A00 + 16'(i));
    end

    // R2 control write while running is ignored
    wr(3'd0, 16'h0001);
    @(negedge clk); runEn = 1'b1;
    wr(3'd0, 16'h0002);
    @(negedge clk); runEn = 1'b0;
    rd(3'd0, v); check("R2 ctrl frozen", v, 16'h0001);

    // R3 stopped counter holds
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0100);
    repeat (20) @(negedge clk);
    rd(3'd1, v); check("R3 hold", v, 16'h0100);

    // R4 undivided clock, edge select ignored
    wr(3'd1, 16'h0000); runFor(37); rd(3'd1, v); check("R4 per clock", v, 16'd37);
    wr(3'd0, 16'h0018); runFor(20); rd(3'd1, v); check("R4 both ignored", v, 16'd57);
    wr(3'd0, 16'h0008); runFor(3); rd(3'd1, v); check("R4 falling ignored", v, 16'd60);

    // R5 prescaled sources
    for (int p = 1; p <= 3; p++) begin
      for (int e = 0; e <= 2; e++) begin
        int divN;
        divN = 4 ** p;
        wr(3'd0, 16'((e << 3) | p));
        wr(3'd1, 16'h0000);
        runFor(5 * divN);
        rd(3'd1, v);
        check("R5 prescale rate", v, (e == 2) ? 16'd10 : 16'd5);
      end
    end

    // R6 external pin
    for (int e = 0; e <= 2; e++) begin
      wr(3'd0, 16'((e << 3) | ((e == 1) ? 7 : 4)));
      wr(3'd1, 16'h0000);
      @(negedge clk); runEn = 1'b1;
      for (int m = 0; m < 4; m++) begin
        repeat (3) @(negedge clk); extClk = 1'b1;
        repeat (3) @(negedge clk); extClk = 1'b0;
      end
      repeat (6) @(negedge clk); runEn = 1'b0;
      rd(3'd1, v);
      check("R6 external edges", v, (e == 2) ? 16'd8 : 16'd4);
    end

    // R7 clear on each compare, R9 flags
    ca = 16'd9; cb = 16'd5; cc = 16'd12; cd = 16'd7;
    wr(3'd2, ca); wr(3'd3, cb); wr(3'd4, cc); wr(3'd5, cd);
    begin
      logic [2:0] codes [4];
      codes[0] = 3'b001; codes[1] = 3'b010; codes[2] = 3'b101; codes[3] = 3'b110;
      for (int i = 0; i < 4; i++) begin
        wr(3'd6, 16'h000F);
        wr(3'd0, 16'(codes[i]) << 5);
        wr(3'd1, 16'h0000);
        runFor(30);
        model(codes[i], ca, cb, cc, cd, 16'h0000, 30, expCnt, expFl);
        rd(3'd1, v); check("R7 clear select", v, expCnt);
        rd(3'd6, v); check("R9 flags after run", v, 16'(expFl));
      end
    end

    // R9 write-one-to-clear and stickiness
    wr(3'd6, 16'h0001);
    rd(3'd6, v); check("R9 w1c bit0", v, 16'(expFl & 4'b1110));
    wr(3'd6, 16'h0000);
    rd(3'd6, v); check("R9 zero write keeps", v, 16'(expFl & 4'b1110));
    check("R9 flag pins", 16'(matchFlag), 16'(expFl & 4'b1110));

    // R8 no-clear codes and wrap
    wr(3'd2, 16'd3); wr(3'd3, 16'd3); wr(3'd4, 16'd3); wr(3'd5, 16'd3);
    begin
      logic [2:0] nc [4];
      nc[0] = 3'b000; nc[1] = 3'b100; nc[2] = 3'b011; nc[3] = 3'b111;
      for (int i = 0; i < 4; i++) begin
        wr(3'd0, 16'(nc[i]) << 5);
        wr(3'd1, 16'h0000);
        runFor(20);
        rd(3'd1, v); check("R8 no clear", v, 16'd20);
      end
    end
    wr(3'd0, 16'h0000); wr(3'd1, 16'hFFFD); runFor(5);
    rd(3'd1, v); check("R8 wrap", v, 16'h0002);

    // Random runs on the undivided clock (R4, R7, R8, R9)
    for (int it = 0; it < 40; it++) begin
      logic [2:0] code;
      int n;
      code = 3'($urandom_range(0, 7));
      ca = 16'($urandom_range(0, 40)); cb = 16'($urandom_range(0, 40));
      cc = 16'($urandom_range(0, 40)); cd = 16'($urandom_range(0, 40));
      st = 16'($urandom_range(0, 20));
      n = $urandom_range(1, 150);
      wr(3'd0, (16'(code) << 5) | (16'($urandom_range(0, 3)) << 3));
      wr(3'd2, ca); wr(3'd3, cb); wr(3'd4, cc); wr(3'd5, cd);
      wr(3'd1, st);
      wr(3'd6, 16'h000F);
      runFor(n);
      model(code, ca, cb, cc, cd, st, n, expCnt, expFl);
      rd(3'd1, v); check("R7 random counter", v, expCnt);
      rd(3'd6, v); check("R9 random flags", v, 16'(expFl));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule